// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Wrap Order

This block produces the word address for every beat of a four-beat burst in a synchronous burst memory. Two active-low start strobes can open a burst. One comes from the processor and one from the cache controller. When a start is accepted and the chip is selected, the full external address is captured. From then on, the advance input walks the two low address bits through the burst while the upper bits stay fixed. The walk order comes from a static order input: when that input is low, the beat offset is added to the starting low bits modulo four; when it is high, the beat offset is XORed into them.

The two strobes follow different chip-enable rules. An inactive primary enable blocks the processor strobe completely. The controller strobe is always seen. If the controller strobe arrives while any chip enable is inactive, the burst closes (deselect). The chip-enable inputs matter only in a cycle where a strobe is taken. Every input is registered on the rising clock edge, and the outputs come directly from registers.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears addr_o to 0 and burst_active_o to 0 from the next edge.
- R2: A taken start loads ext_addr_i into addr_o and sets burst_active_o after one edge, provided sel_n=0, sel_hi=1 and sel_lo_n=0. A start is taken when proc_strb_n=0 with sel_n=0, or when ctrl_strb_n=0. A start during a running burst restarts the burst, and two simultaneous strobes load the address once.
- R3: While sel_n=1, proc_strb_n has no effect. The cycle then behaves as if no strobe were present: it holds when step_n=1 and advances a running burst when step_n=0.
- R4: ctrl_strb_n=0 is honoured while sel_n=1. Because the chip is not selected, it clears burst_active_o and leaves addr_o unchanged.
- R5: A taken start while sel_hi=0 or sel_lo_n=1 clears burst_active_o and leaves addr_o unchanged.
- R6: With order_sel=0, each advance (no start, step_n=0, burst active) sets addr_o[1:0] to the starting low bits plus the beat number, modulo 4.
- R7: With order_sel=1, each advance sets addr_o[1:0] to the starting low bits XOR the beat number. From a start of 10 the sequence is 10, 11, 00, 01.
- R8: With no start and step_n=1, addr_o is held (burst suspended).
- R9: After the fourth beat the low bits wrap back to the starting value. addr_o[16:2] never changes except on a load.
- R10: In cycles without a taken strobe, changes on sel_n, sel_hi and sel_lo_n have no effect on either output.
- R11: While burst_active_o=0 and no start is taken, step_n=0 does not change addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr_i | input | 17 | External start address |
| proc_strb_n | input | 1 | Processor start strobe, active low, masked by sel_n |
| ctrl_strb_n | input | 1 | Controller start strobe, active low, never masked |
| step_n | input | 1 | Advance request, active low; high suspends |
| sel_n | input | 1 | Primary chip enable, active low |
| sel_hi | input | 1 | Secondary chip enable, active high |
| sel_lo_n | input | 1 | Tertiary chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | 17 | Current burst address |
| burst_active_o | output | 1 | A selected burst is in progress |

## Verification
The risky collision is a start strobe and an advance request in the same cycle, and more sharply, the processor strobe arriving with the primary enable inactive while step_n is low. In that case the masked strobe must be ignored and the burst must step. The bench drives these overlaps on purpose: both strobes together, a strobe together with step_n low, and a masked processor strobe in the middle of a burst. A behavioural model chooses between load, deselect, step and hold in its own way, and every output is compared against that model on every clock.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int LOW_W = 2;
  typedef logic [LOW_W-1:0] low_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DESEL = 2'd2,
    ACT_STEP  = 2'd3
  } action_t;

  // Low address bits for a given beat: additive (wraps at LOW_W) or XOR.
  function automatic low_t beat_addr(input low_t start, input low_t beat,
                                     input logic interleave);
    low_t r;
    if (interleave) r = start ^ beat;
    else            r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/bas_start_decode.sv
module bas_start_decode
  import bas_pkg::*;
(
  input  logic    proc_strb_n,
  input  logic    ctrl_strb_n,
  input  logic    step_n,
  input  logic    sel_n,
  input  logic    sel_hi,
  input  logic    sel_lo_n,
  input  logic    active,
  output logic    proc_take,
  output logic    ctrl_take,
  output logic    start_any,
  output logic    chip_sel,
  output action_t act
);
  always_comb begin
    proc_take = ~proc_strb_n & ~sel_n;   // primary enable masks processor strobe
    ctrl_take = ~ctrl_strb_n & ~proc_take; // processor wins when both are taken
    start_any = proc_take | ctrl_take;
    chip_sel  = ~sel_n & sel_hi & ~sel_lo_n;
    if (start_any)               act = chip_sel ? ACT_LOAD : ACT_DESEL;
    else if (active && !step_n)  act = ACT_STEP;
    else                         act = ACT_HOLD;
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  output low_t beat_q,
  output low_t beat_next
);
  assign beat_next = beat_q + low_t'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) beat_q <= '0;
    else if (adv)     beat_q <= beat_next;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              step_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_active_o
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic              proc_take, ctrl_take, start_any, chip_sel;
  action_t           act;
  low_t              beat_q, beat_next, start_low_q, next_low;
  logic [HI_W-1:0]   hi_q;
  low_t              lo_q;
  logic              active_q;

  bas_start_decode u_dec (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .step_n      (step_n),
    .sel_n       (sel_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .active      (active_q),
    .proc_take   (proc_take),
    .ctrl_take   (ctrl_take),
    .start_any   (start_any),
    .chip_sel    (chip_sel),
    .act         (act)
  );

  bas_beat_ctr u_beat (
    .clk       (clk),
    .rst       (rst),
    .clear     (act == ACT_LOAD),
    .adv       (act == ACT_STEP),
    .beat_q    (beat_q),
    .beat_next (beat_next)
  );

  assign next_low = beat_addr(start_low_q, beat_next, order_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q        <= '0;
      lo_q        <= '0;
      start_low_q <= '0;
      active_q    <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD: begin
          hi_q        <= ext_addr_i[ADDR_W-1:LOW_W];
          lo_q        <= ext_addr_i[LOW_W-1:0];
          start_low_q <= ext_addr_i[LOW_W-1:0];
          active_q    <= 1'b1;
        end
        ACT_DESEL: active_q <= 1'b0;
        ACT_STEP:  lo_q     <= next_low;
        default: ;
      endcase
    end
  end

  assign addr_o         = {hi_q, lo_q};
  assign burst_active_o = active_q;
endmodule

// File: rtl/bas_assert.sv
module bas_assert #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              step_n,
  input logic              sel_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_o,
  input logic              burst_active_o,
  input logic              start_any,
  input logic              chip_sel
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && !burst_active_o));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (start_any && chip_sel) |=> (addr_o == $past(ext_addr_i) && burst_active_o));

  assert_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && sel_n && ctrl_strb_n && step_n) |=>
      ($stable(addr_o) && $stable(burst_active_o)));

  assert_ctrl_desel_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_strb_n && sel_n) |=> (!burst_active_o && $stable(addr_o)));

  assert_desel_R5: assert property (@(posedge clk) disable iff (rst)
    (start_any && !chip_sel) |=> (!burst_active_o && $stable(addr_o)));

  assert_linear_R6: assert property (@(posedge clk) disable iff (rst)
    (!start_any && burst_active_o && !step_n && !order_sel) |=>
      (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));

  assert_suspend_R8: assert property (@(posedge clk) disable iff (rst)
    (!start_any && step_n) |=> $stable(addr_o));

  assert_upper_R9: assert property (@(posedge clk) disable iff (rst)
    !start_any |=> $stable(addr_o[ADDR_W-1:2]));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!start_any && !burst_active_o) |=> ($stable(addr_o) && !burst_active_o));
endmodule

bind burst_addr_seq bas_assert #(.ADDR_W(ADDR_W)) u_bas_assert (
  .clk            (clk),
  .rst            (rst),
  .ext_addr_i     (ext_addr_i),
  .proc_strb_n    (proc_strb_n),
  .ctrl_strb_n    (ctrl_strb_n),
  .step_n         (step_n),
  .sel_n          (sel_n),
  .order_sel      (order_sel),
  .addr_o         (addr_o),
  .burst_active_o (burst_active_o),
  .start_any      (start_any),
  .chip_sel       (chip_sel)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [16:0] ext_addr_i;
  logic        proc_strb_n, ctrl_strb_n, step_n, sel_n, sel_hi, sel_lo_n, order_sel;
  logic [16:0] addr_o;
  logic        burst_active_o;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_addr = 0, m_start = 0, m_beat = 0;
  bit m_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst(rst), .ext_addr_i(ext_addr_i),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .step_n(step_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .order_sel(order_sel),
    .addr_o(addr_o), .burst_active_o(burst_active_o)
  );

  task automatic model_edge();
    bit p, c, ok;
    int low;
    if (rst) begin
      m_addr = 0; m_start = 0; m_beat = 0; m_act = 0;
    end else begin
      p  = (proc_strb_n == 0) && (sel_n == 0);
      c  = (ctrl_strb_n == 0);
      ok = (sel_n == 0) && (sel_hi == 1) && (sel_lo_n == 0);
      if (p || c) begin
        if (ok) begin
          m_addr = int'(ext_addr_i); m_start = m_addr % 4; m_beat = 0; m_act = 1;
        end else m_act = 0;
      end else if (m_act && step_n == 0) begin
        m_beat = (m_beat + 1) % 4;
        low = order_sel ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
        m_addr = (m_addr / 4) * 4 + low;
      end
    end
  endtask

  task automatic cyc(input bit r, input bit pn, input bit cn, input bit sn,
                     input bit s0n, input bit s2, input bit s3n, input bit md,
                     input logic [16:0] a, input string tag);
    @(negedge clk);
    rst = r; proc_strb_n = pn; ctrl_strb_n = cn; step_n = sn;
    sel_n = s0n; sel_hi = s2; sel_lo_n = s3n; order_sel = md; ext_addr_i = a;
    @(posedge clk);
    model_edge();
    #1;
    checks++;
    if (int'(addr_o) != m_addr) begin
      fails++;
      $display("FAIL %s addr actual=%h expected=%h", tag, addr_o, m_addr);
    end
    checks++;
    if (burst_active_o != m_act) begin
      fails++;
      $display("FAIL %s active actual=%0d expected=%0d", tag, burst_active_o, m_act);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset
    cyc(1,1,1,1, 0,1,0,0, 17'h1ABC1, "R1");
    cyc(1,1,1,0, 0,1,0,0, 17'h1ABC1, "R1");
    // R2 processor start, linear order R6 with wrap R9
    cyc(0,0,1,1, 0,1,0,0, 17'h1ABC1, "R2");
    for (int i = 0; i < 5; i++) cyc(0,1,1,0, 0,1,0,0, 17'h00000, "R6_R9");
    // R8 suspend
    cyc(0,1,1,1, 0,1,0,0, 17'h0FFFF, "R8");
    cyc(0,1,1,1, 0,1,0,0, 17'h0FFFF, "R8");
    // R7 interleaved via controller strobe, start low bits 10
    cyc(0,1,0,1, 0,1,0,1, 17'h05556, "R2");
    for (int i = 0; i < 5; i++) cyc(0,1,1,0, 0,1,0,1, 17'h1FFFF, "R7_R9");
    // R3 masked processor strobe: hold, then step
    cyc(0,0,1,1, 1,1,0,1, 17'h12340, "R3");
    cyc(0,0,1,0, 1,1,0,1, 17'h12340, "R3");
    // R10 enables wiggle without strobes
    cyc(0,1,1,1, 1,0,1,1, 17'h00003, "R10");
    cyc(0,1,1,1, 0,0,1,1, 17'h00003, "R10");
    cyc(0,1,1,0, 1,0,1,1, 17'h00003, "R10");
    // R4 controller strobe with primary enable off deselects
    cyc(0,1,0,0, 1,1,0,0, 17'h0AAAA, "R4");
    // R11 advance while idle
    cyc(0,1,1,0, 0,1,0,0, 17'h0AAAA, "R11");
    cyc(0,1,1,0, 1,1,0,0, 17'h0AAAA, "R11");
    // R5 restart, then deselect via secondary enables
    cyc(0,0,1,1, 0,1,0,0, 17'h1FFFF, "R2");
    cyc(0,0,1,0, 0,0,0,0, 17'h00001, "R5");
    cyc(0,0,1,1, 0,1,0,0, 17'h1FFFF, "R2");
    cyc(0,1,0,0, 0,1,1,0, 17'h00001, "R5");
    // both strobes together, plus step low in same cycle
    cyc(0,0,0,0, 0,1,0,0, 17'h1FFFF, "R2");
    cyc(0,1,1,0, 0,1,0,0, 17'h00000, "R9");
    cyc(0,1,1,0, 0,1,0,0, 17'h00000, "R9");
    // restart mid-burst, interleave from 11
    cyc(0,0,1,0, 0,1,0,1, 17'h02463, "R2");
    for (int i = 0; i < 4; i++) cyc(0,1,1,0, 0,1,0,1, 17'h00000, "R7");
    // reset mid-burst
    cyc(1,1,1,0, 0,1,0,1, 17'h00000, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule